// File: doc/BRIEF.md
# Digit-Serial Word Adder

This block adds two 32-bit words two bits at a time, which trades latency for a very small adder. A start strobe captures both operands and clears the running carry. On each of the next 16 clock cycles a selector takes one 2-bit digit from each captured operand, beginning with the least significant digit. A 2-bit adder slice adds the two digits and the carry held in a register from the previous digit. The 2-bit sum digit is shifted into a 32-bit result register from the top end.

After the sixteenth digit the full sum and the final carry-out are ready, and a done flag pulses for one cycle. The result and the carry keep their values until the next accepted start. A start that arrives while an addition is still running is ignored. The digit width and the word width are parameters, and the digit count follows from them.

Top module: `dsa_word_adder`

## Requirements
- R1: While rst_ni is low and after its release, sum_o is 0, carry_o is 0 and done_o is 0.
- R2: A start_i seen high at a rising edge while no addition runs captures op_a_i and op_b_i at that edge. Later changes on the operand inputs do not affect the result.
- R3: When done_o is high, {carry_o, sum_o} equals the 33-bit sum of the captured operands.
- R4: done_o goes high exactly 16 rising edges after the edge that accepted start_i, and it stays high for exactly one cycle.
- R5: The carry register is cleared when a start is accepted. A carry-out of 1 from one addition does not enter the first digit of the next addition.
- R6: A start_i that is high while an addition runs is ignored. The running result and the done timing do not change.
- R7: With no accepted start, sum_o and carry_o hold their values from the cycle after done_o until the next accepted start.
- R8: A start_i that is high in the same cycle as done_o is accepted and begins a new addition.
- R9: Digits are handled least significant first. Each sum digit enters the result register at bits [31:30], and the register shifts right by 2 each digit cycle. One cycle after the start edge, sum_o[31:30] equals bits [1:0] of the sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an addition when idle |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand |
| sum_o | output | 32 | Result word |
| carry_o | output | 1 | Carry out of the most significant digit |
| done_o | output | 1 | One-cycle pulse when the result is complete |

## Verification
The bench uses all-ones plus one and all-ones plus all-ones to test carry chains through every digit. A slice that drops or delays its carry gives a wrong upper sum or a missing carry-out. Running 0 plus 0 right after an addition with a carry-out of 1 catches a carry register that is not cleared at start, which would return 1 instead of 0. The bench also drives a second start in the middle of a run, a start on the done cycle, and operand changes after capture. These catch a controller that restarts, one that misses back-to-back work, and one that reads live inputs. A selector that walks digits in the wrong order fails the check that the first sum digit appears at the top of the result one cycle after start.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dsa_state_e;
endpackage

// File: rtl/dsa_digit_mux.sv
module dsa_digit_mux #(
  parameter int WORD_W  = 32,
  parameter int DIGIT_W = 2,
  localparam int NUM_DIGITS = WORD_W / DIGIT_W,
  localparam int SEL_W      = $clog2(NUM_DIGITS)
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [DIGIT_W-1:0] digit_o
);
  logic [DIGIT_W-1:0] digits [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_split
    assign digits[g] = word_i[g*DIGIT_W +: DIGIT_W];
  end

  assign digit_o = digits[sel_i];
endmodule

// File: rtl/dsa_digit_slice.sv
module dsa_digit_slice #(
  parameter int DIGIT_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               en_i,
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  output logic [DIGIT_W-1:0] sum_o,
  output logic               carry_o
);
  logic               carry_q;
  logic [DIGIT_W:0]   total;

  assign total = {1'b0, a_i} + {1'b0, b_i} + {{DIGIT_W{1'b0}}, carry_q};
  assign sum_o   = total[DIGIT_W-1:0];
  assign carry_o = carry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      carry_q <= 1'b0;
    else if (clear_i) carry_q <= 1'b0;
    else if (en_i)    carry_q <= total[DIGIT_W];
  end
endmodule

// File: rtl/dsa_sum_shreg.sv
module dsa_sum_shreg #(
  parameter int WORD_W  = 32,
  parameter int DIGIT_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [WORD_W-1:0]  word_o
);
  logic [WORD_W-1:0] word_q;

  // new digit enters at the top; after a full pass digit 0 sits at the bottom
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (load_i)  word_q <= '0;
    else if (shift_i) word_q <= {digit_i, word_q[WORD_W-1:DIGIT_W]};
  end

  assign word_o = word_q;
endmodule

// File: rtl/dsa_word_adder.sv
module dsa_word_adder #(
  parameter int WORD_W  = 32,
  parameter int DIGIT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              carry_o,
  output logic              done_o
);
  import dsa_pkg::*;

  localparam int NUM_DIGITS = WORD_W / DIGIT_W;
  localparam int SEL_W      = $clog2(NUM_DIGITS);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_DIGITS - 1);

  dsa_state_e         state_q;
  logic [SEL_W-1:0]   sel_q;
  logic [WORD_W-1:0]  a_q, b_q;
  logic               done_q;
  logic               busy, accept, last;
  logic [DIGIT_W-1:0] dig_a, dig_b, dig_sum;

  assign busy   = (state_q == ST_RUN);
  assign accept = start_i && !busy;
  assign last   = busy && (sel_q == LAST_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        state_q <= ST_RUN;
        sel_q   <= '0;
        a_q     <= op_a_i;
        b_q     <= op_b_i;
      end else if (busy) begin
        sel_q <= sel_q + 1'b1;
        if (last) state_q <= ST_IDLE;
      end
    end
  end

  dsa_digit_mux #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u_mux_a (
    .word_i(a_q), .sel_i(sel_q), .digit_o(dig_a)
  );

  dsa_digit_mux #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u_mux_b (
    .word_i(b_q), .sel_i(sel_q), .digit_o(dig_b)
  );

  dsa_digit_slice #(.DIGIT_W(DIGIT_W)) u_slice (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(accept),
    .en_i   (busy),
    .a_i    (dig_a),
    .b_i    (dig_b),
    .sum_o  (dig_sum),
    .carry_o(carry_o)
  );

  dsa_sum_shreg #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .shift_i(busy),
    .digit_i(dig_sum),
    .word_o (sum_o)
  );

  assign done_o = done_q;
endmodule

// File: rtl/dsa_word_adder_chk.sv
module dsa_word_adder_chk #(
  parameter int WORD_W  = 32,
  parameter int DIGIT_W = 2,
  localparam int NUM_DIGITS = WORD_W / DIGIT_W,
  localparam int SEL_W      = $clog2(NUM_DIGITS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [WORD_W-1:0] op_a_i,
  input logic [WORD_W-1:0] op_b_i,
  input logic [WORD_W-1:0] sum_o,
  input logic              carry_o,
  input logic              done_o,
  input logic              busy_i,
  input logic [SEL_W-1:0]  sel_i
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_DIGITS - 1);

  logic [WORD_W:0] ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ref_q <= '0;
    else if (start_i && !busy_i) ref_q <= {1'b0, op_a_i} + {1'b0, op_b_i};
  end

  p_result_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({carry_o, sum_o} == ref_q));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && sel_i == LAST_SEL) |=> (done_o && !busy_i));

  p_start_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> (busy_i && sel_i == '0 && !carry_o && sum_o == '0));

  p_busy_start_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && sel_i != LAST_SEL) |=> (busy_i && sel_i == SEL_W'($past(sel_i) + 1'b1)));

  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> ($stable(sum_o) && $stable(carry_o)));

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_i);
endmodule

bind dsa_word_adder dsa_word_adder_chk #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .op_a_i (op_a_i),
  .op_b_i (op_b_i),
  .sum_o  (sum_o),
  .carry_o(carry_o),
  .done_o (done_o),
  .busy_i (busy),
  .sel_i  (sel_q)
);

// File: tb/dsa_word_adder_bench.sv
module dsa_word_adder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic [31:0] sum_o;
  logic        carry_o;
  logic        done_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk_i = ~clk_i;

  dsa_word_adder u_dsa_word_adder (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i),
    .sum_o(sum_o), .carry_o(carry_o), .done_o(done_o)
  );

  localparam int NVEC = 8;
  localparam logic [63:0] VEC [NVEC] = '{
    {32'hFFFF_FFFF, 32'h0000_0001},
    {32'h0000_0000, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h1234_5678, 32'h9ABC_DEF0},
    {32'hAAAA_AAAA, 32'h5555_5555},
    {32'h8000_0000, 32'h8000_0000},
    {32'hDEAD_BEEF, 32'h0102_0304},
    {32'h7FFF_FFFF, 32'h0000_0001}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // call at a negedge; returns at the negedge after the accepting edge
  task automatic launch(input logic [31:0] a, input logic [31:0] b);
    start_i = 1'b1; op_a_i = a; op_b_i = b;
    @(posedge clk_i); @(negedge clk_i);
    start_i = 1'b0; op_a_i = ~a; op_b_i = a ^ 32'h5A5A_A5A5;  // R2 garbage after capture
  endtask

  // returns at the negedge where done_o is high (or after timeout)
  task automatic wait_done(input logic [31:0] a, input logic [31:0] b, input bit mid_start);
    logic [32:0] exp;
    int cnt;
    exp = {1'b0, a} + {1'b0, b};
    cnt = 0;
    while (!done_o && cnt < 40) begin
      @(posedge clk_i); @(negedge clk_i);
      cnt++;
      if (cnt == 1)
        check(sum_o[31:30] == exp[1:0], "R9 first digit at top", 64'(sum_o[31:30]), 64'(exp[1:0]));
      if (mid_start && cnt == 5) begin
        start_i = 1'b1; op_a_i = 32'h1111_1111; op_b_i = 32'h2222_2222;
      end
      if (mid_start && cnt == 6) start_i = 1'b0;
    end
    check(cnt == 16, mid_start ? "R6 done timing with busy start" : "R4 done latency",
          64'(cnt), 64'd16);
    check({carry_o, sum_o} == exp, mid_start ? "R6 result with busy start" : "R3 sum",
          64'({carry_o, sum_o}), 64'(exp));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [31:0] ra, rb, hs;
    logic        hc;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(sum_o == 0 && carry_o == 0 && done_o == 0, "R1 in reset",
          {31'd0, done_o, sum_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(sum_o == 0 && carry_o == 0 && done_o == 0, "R1 after release",
          {31'd0, done_o, sum_o}, 64'd0);

    // table walk (R2 operands scrambled after capture, R3, R4, R9)
    for (int i = 0; i < NVEC; i++) begin
      launch(VEC[i][63:32], VEC[i][31:0]);
      wait_done(VEC[i][63:32], VEC[i][31:0], 1'b0);
      @(posedge clk_i); @(negedge clk_i);
      check(done_o == 1'b0, "R4 done one cycle", 64'(done_o), 64'd0);
      repeat (2) @(negedge clk_i);
    end

    // R5: carry-out 1, then 0+0 must give carry 0
    launch(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wait_done(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    check(carry_o == 1'b1, "R5 carry set before", 64'(carry_o), 64'd1);
    @(negedge clk_i);
    launch(32'h0, 32'h0);
    check(carry_o == 1'b0 && sum_o == 0, "R5 carry cleared at start", 64'({carry_o, sum_o}), 64'd0);
    wait_done(32'h0, 32'h0, 1'b0);
    check(carry_o == 1'b0, "R5 no carry leak", 64'(carry_o), 64'd0);

    // R6 start while busy ignored
    @(negedge clk_i);
    launch(32'hCAFE_F00D, 32'h3501_0FF3);
    wait_done(32'hCAFE_F00D, 32'h3501_0FF3, 1'b1);

    // R7 hold after done
    hs = sum_o; hc = carry_o;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      op_a_i = $urandom; op_b_i = $urandom;
    end
    check(sum_o == hs && carry_o == hc, "R7 result held",
          64'({carry_o, sum_o}), 64'({hc, hs}));
    check(done_o == 1'b0, "R7 done low while idle", 64'(done_o), 64'd0);

    // R8 start on the done cycle
    launch(32'h0F0F_0F0F, 32'hF0F0_F0F1);
    wait_done(32'h0F0F_0F0F, 32'hF0F0_F0F1, 1'b0);
    launch(32'h8765_4321, 32'h789A_BCDF);
    check(done_o == 1'b0 && sum_o == 0, "R8 back-to-back accepted", 64'({done_o, sum_o}), 64'd0);
    wait_done(32'h8765_4321, 32'h789A_BCDF, 1'b0);

    // random operands (R3)
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_i);
      ra = $urandom; rb = $urandom;
      launch(ra, rb);
      wait_done(ra, rb, 1'b0);
    end

    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule